// File: doc/BRIEF.md
# Smart card T=0 character transceiver

This block moves asynchronous smart card characters over one open-drain I/O line, one direction at a time. A character is a low start bit, eight data bits sent least significant first, and an even parity bit. The character is followed by at least two ETUs of guard time, during which the receiving side may hold the line low to reject the character. The block runs from a sample strobe supplied from outside, `sample_tick`, which fires `TICKS_PER_ETU` times per ETU. Dividing that strobe down to the wanted baud rate is left to the surrounding logic.

The host reaches the block through four byte-wide registers. Writing the data register queues a byte for transmission. Reading the data register removes the oldest received byte. Each direction has a two-entry queue. A control register selects the T=0 error behaviour:

- receive parity checking;
- reporting a receive parity error to the host, enabled separately from rejecting the character on the line;
- automatic resend of a transmitted byte that the card rejected, limited by a programmable count;
- dropping a received byte whose parity was wrong;
- a test mode that sends wrong parity on purpose.

When no character is moving, the block starts receiving on a falling edge of the line. Otherwise, if a byte is queued and the line is high, it starts transmitting.

Top module: `sc_t0_xcvr`

## Requirements
- R1: After reset, STATUS reads 0x04, CTRL reads 0x17, LIMIT reads 0x03, and `io_pull_low` and `irq` are 0.
- R2: A queued byte is sent as follows. `io_pull_low`=1 means a line bit of 0. The start bit is 0, then data bits 0..7, then the parity bit, which makes the ten line bits even. The line is then released (bit 10 reads 1). A transmit occupies 13 ETU.
- R3: A received character is taken by a 2-of-3 vote of the line samples at ticks H-1, H and H+1 of each bit, where H=TICKS_PER_ETU/2. The byte is queued. STATUS[0] (receive data present) and `irq` go to 1. A read of DATA (address 0) returns the oldest byte.
- R4: Both queues hold two bytes. STATUS[1] shows receive full, STATUS[2] transmit empty and STATUS[3] transmit full. A DATA write to a full transmit queue is ignored. A character that arrives while the receive queue is full is dropped.
- R5: With CTRL[0]=0, parity is not checked: a wrongly parity-coded character is stored, flags nothing and is not rejected on the line.
- R6: With checking on, a parity error sets sticky STATUS[4] only when CTRL[1]=1. It pulls the line low from 10.5 to 11.5 ETU after the start edge only when CTRL[2]=1. The two enables act independently.
- R7: CTRL[3]=1 inverts the transmitted parity bit.
- R8: If the line is low at 11 ETU of a transmit and CTRL[4]=1, the same byte is sent again, up to LIMIT (address 3) extra times.
- R9: When a rejection occurs after LIMIT resends have been used (this includes LIMIT=0), sticky STATUS[5] is set, the byte is dropped and the next queued byte is handled with a fresh count.
- R10: With CTRL[4]=0, a rejection is ignored: the byte is dropped and no flag is set.
- R11: With CTRL[5]=1, a received byte whose parity check fails is not stored.
- R12: Writing STATUS (address 2) with 1s in bits 4 and 5 clears those sticky bits. The other bits are unaffected.
- R13: A receive-queue push and a host DATA read in the same cycle both take effect.
- R14: A low pulse that is not low at the vote of the start bit is ignored and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | Sample strobe, TICKS_PER_ETU per ETU |
| io_in | input | 1 | Level of the card I/O line |
| io_pull_low | output | 1 | 1 pulls the open-drain I/O line low |
| reg_addr | input | 2 | Register select: 0 DATA, 1 CTRL, 2 STATUS, 3 LIMIT |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Register read strobe (a DATA read pops) |
| reg_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Receive data present or a sticky error set |

## Verification
The receiver can push a finished character into the receive queue in the same cycle that the host reads DATA and pops the queue. The bench holds one byte in the queue, sends a second character, and issues the DATA read at each of forty successive clock offsets spanning the push cycle. Whatever the offset, the read must return the first byte, the second byte must remain, and the queue must then read empty, so a lost or doubled count shows up as a wrong byte or wrong status.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} eng_state_t;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_LIM  = 2'd3;

  localparam logic [7:0] CTRL_RST = 8'h17;
  localparam int         LIM_RST  = 3;
endpackage

// File: rtl/sc_fifo.sv
module sc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
  localparam logic [AW-1:0] PTR_MAX = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNT_MAX);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= (wptr == PTR_MAX) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == PTR_MAX) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R4: a push into a full queue without a pop leaves the fill level alone
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt));

  // R13: simultaneous push and pop on a non-empty queue keeps the fill level
  a_r13_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty) |=> $stable(cnt));
endmodule

// File: rtl/sc_line_sampler.sv
module sc_line_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic io_in,
  output logic line_s,
  output logic fall,
  output logic vote
);
  logic s1, s2, h0, h1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      h0 <= 1'b1;
      h1 <= 1'b1;
    end else begin
      s1 <= io_in;
      s2 <= s1;
      if (tick) begin
        h1 <= h0;
        h0 <= s2;
      end
    end
  end

  assign line_s = s2;
  assign fall   = tick && h0 && !s2;
  assign vote   = (h1 & h0) | (h1 & s2) | (h0 & s2);
endmodule

// File: rtl/sc_char_engine.sv
module sc_char_engine
  import sc_t0_pkg::*;
#(
  parameter int TICKS_PER_ETU = 8,
  parameter int RW            = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          line_s,
  input  logic          fall,
  input  logic          vote,
  input  logic          tx_valid,
  input  logic [7:0]    tx_byte,
  input  logic          chk_en,
  input  logic          report_en,
  input  logic          errsig_en,
  input  logic          force_bad,
  input  logic          resend_en,
  input  logic          discard_en,
  input  logic [RW-1:0] limit,
  output logic          pull_low,
  output logic          rx_push,
  output logic [7:0]    rx_byte,
  output logic          tx_pop,
  output logic          par_evt,
  output logic          exh_evt
);
  localparam int TW = $clog2(TICKS_PER_ETU);
  localparam logic [TW-1:0] T_LAST = TW'(TICKS_PER_ETU - 1);
  localparam logic [TW-1:0] T_MID  = TW'(TICKS_PER_ETU / 2);
  localparam logic [TW-1:0] T_VOTE = TW'(TICKS_PER_ETU / 2 + 1);

  eng_state_t    state;
  logic [TW-1:0] tcnt;
  logic [3:0]    bitn;
  logic [7:0]    txsh, rxsh;
  logic          errsig, nack, drive, rx_bad;
  logic [RW-1:0] retry;
  logic [2:0]    bsel;

  assign bsel    = 3'(bitn - 4'd1);
  assign rx_bad  = chk_en && ((^rxsh) ^ vote);
  assign rx_byte = rxsh;

  always_comb begin
    drive = 1'b0;
    case (state)
      ST_TX: begin
        if (bitn == 4'd0)      drive = 1'b1;
        else if (bitn <= 4'd8) drive = ~txsh[bsel];
        else if (bitn == 4'd9) drive = ~((^txsh) ^ force_bad);
      end
      ST_RX: drive = errsig && ((bitn == 4'd10 && tcnt >= T_MID) ||
                                (bitn == 4'd11 && tcnt <  T_MID));
      default: drive = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      tcnt     <= '0;
      bitn     <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      errsig   <= 1'b0;
      nack     <= 1'b0;
      retry    <= '0;
      pull_low <= 1'b0;
      rx_push  <= 1'b0;
      tx_pop   <= 1'b0;
      par_evt  <= 1'b0;
      exh_evt  <= 1'b0;
    end else begin
      pull_low <= drive;
      rx_push  <= 1'b0;
      tx_pop   <= 1'b0;
      par_evt  <= 1'b0;
      exh_evt  <= 1'b0;
      if (tick) begin
        if (state != ST_IDLE) begin
          if (tcnt == T_LAST) begin
            tcnt <= '0;
            bitn <= bitn + 4'd1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        case (state)
          ST_IDLE: begin
            tcnt <= '0;
            bitn <= '0;
            if (fall) begin
              state  <= ST_RX;
              errsig <= 1'b0;
            end else if (tx_valid && line_s) begin
              state <= ST_TX;
              txsh  <= tx_byte;
              nack  <= 1'b0;
            end
          end
          ST_RX: begin
            if (tcnt == T_VOTE) begin
              if (bitn == 4'd0) begin
                if (vote) state <= ST_IDLE;
              end else if (bitn <= 4'd8) begin
                rxsh <= {vote, rxsh[7:1]};
              end else if (bitn == 4'd9) begin
                par_evt <= rx_bad && report_en;
                errsig  <= rx_bad && errsig_en;
                rx_push <= !(rx_bad && discard_en);
              end
            end
            if (bitn == 4'd11 && tcnt == T_LAST) state <= ST_IDLE;
          end
          ST_TX: begin
            if (bitn == 4'd11 && tcnt == '0) nack <= !line_s;
            if (bitn == 4'd12 && tcnt == T_LAST) begin
              state <= ST_IDLE;
              if (nack && resend_en && (retry < limit)) begin
                retry <= retry + 1'b1;
              end else begin
                tx_pop  <= 1'b1;
                retry   <= '0;
                exh_evt <= nack && resend_en;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: after two idle cycles the line is released
  a_r2_release_idle: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && $past(state) == ST_IDLE) |-> !pull_low);

  // R6: while receiving, the line is only pulled inside the rejection window
  a_r6_errsig_window: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RX && pull_low) |-> (bitn == 4'd10 || bitn == 4'd11));

  // R8: a byte leaves the transmit queue only when a 13-ETU frame has ended
  a_r8_pop_at_end: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> (state == ST_IDLE && $past(state) == ST_TX && $past(bitn) == 4'd12));
endmodule

// File: rtl/sc_t0_xcvr.sv
module sc_t0_xcvr
  import sc_t0_pkg::*;
#(
  parameter int TICKS_PER_ETU = 8,
  parameter int FIFO_DEPTH    = 2,
  parameter int RETRY_W       = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_tick,
  input  logic       io_in,
  output logic       io_pull_low,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_rd,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [7:0]         ctrl;
  logic [RETRY_W-1:0] limit;
  logic               par_st, exh_st;
  logic               line_s, fall, vote;
  logic               rx_push, tx_pop, par_evt, exh_evt;
  logic [7:0]         rx_byte, rx_dout, tx_dout, status;
  logic               rx_empty, rx_full, tx_empty, tx_full;
  logic               wr_data, rd_data, wr_stat;

  assign wr_data = reg_wr && reg_addr == A_DATA;
  assign rd_data = reg_rd && reg_addr == A_DATA;
  assign wr_stat = reg_wr && reg_addr == A_STAT;
  assign status  = {2'b00, exh_st, par_st, tx_full, tx_empty, rx_full, !rx_empty};

  sc_line_sampler u_smp (
    .clk(clk), .rst(rst), .tick(sample_tick), .io_in(io_in),
    .line_s(line_s), .fall(fall), .vote(vote)
  );

  sc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(wr_data), .din(reg_wdata), .pop(tx_pop),
    .dout(tx_dout), .empty(tx_empty), .full(tx_full)
  );

  sc_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte), .pop(rd_data),
    .dout(rx_dout), .empty(rx_empty), .full(rx_full)
  );

  sc_char_engine #(.TICKS_PER_ETU(TICKS_PER_ETU), .RW(RETRY_W)) u_eng (
    .clk(clk), .rst(rst), .tick(sample_tick), .line_s(line_s), .fall(fall),
    .vote(vote), .tx_valid(!tx_empty), .tx_byte(tx_dout),
    .chk_en(ctrl[0]), .report_en(ctrl[1]), .errsig_en(ctrl[2]),
    .force_bad(ctrl[3]), .resend_en(ctrl[4]), .discard_en(ctrl[5]),
    .limit(limit), .pull_low(io_pull_low), .rx_push(rx_push),
    .rx_byte(rx_byte), .tx_pop(tx_pop), .par_evt(par_evt), .exh_evt(exh_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= CTRL_RST;
      limit     <= RETRY_W'(LIM_RST);
      par_st    <= 1'b0;
      exh_st    <= 1'b0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_CTRL) ctrl  <= reg_wdata;
      if (reg_wr && reg_addr == A_LIM)  limit <= reg_wdata[RETRY_W-1:0];
      if (par_evt)                        par_st <= 1'b1;
      else if (wr_stat && reg_wdata[4])   par_st <= 1'b0;
      if (exh_evt)                        exh_st <= 1'b1;
      else if (wr_stat && reg_wdata[5])   exh_st <= 1'b0;
      if (reg_rd) begin
        case (reg_addr)
          A_DATA:  reg_rdata <= rx_dout;
          A_CTRL:  reg_rdata <= ctrl;
          A_STAT:  reg_rdata <= status;
          default: reg_rdata <= 8'(limit);
        endcase
      end
      irq <= !rx_empty || par_st || exh_st;
    end
  end

  // R12: a write-one-to-clear removes the parity flag unless a new error lands
  a_r12_w1c_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata[4] && !par_evt) |=> !par_st);
endmodule

// File: tb/sim_sc_t0_xcvr.sv
module sim_sc_t0_xcvr;
  localparam int ETU = 32;
  localparam logic [1:0] AD = 2'd0, AC = 2'd1, AS = 2'd2, AL = 2'd3;

  logic clk = 1'b0, rst = 1'b1, sample_tick = 1'b0, card_low = 1'b0;
  logic io_in, io_pull_low, reg_wr = 1'b0, reg_rd = 1'b0, irq;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [1:0] tdiv = '0;
  int n_chk = 0, n_bad = 0;

  assign io_in = !(card_low || io_pull_low);
  always #2 clk = ~clk;
  always @(posedge clk) begin
    tdiv        <= tdiv + 2'd1;
    sample_tick <= (tdiv == 2'd3);
  end

  sc_t0_xcvr u0 (.clk(clk), .rst(rst), .sample_tick(sample_tick), .io_in(io_in),
    .io_pull_low(io_pull_low), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    hrd(a, v);
    chk(req, v, exp);
  endtask

  // card drives one character; reports whether the block rejected it at ~11 ETU
  task automatic card_send(input logic [7:0] b, input bit badp, output bit saw);
    logic [9:0] fr;
    fr  = {(^b) ^ badp, b, 1'b0};
    saw = 1'b0;
    for (int i = 0; i < 14 * ETU; i++) begin
      @(negedge clk);
      card_low = (i < 10 * ETU) ? !fr[i / ETU] : 1'b0;
      if (i == 356) saw = io_pull_low;
    end
  endtask

  // card listens for one character; optionally rejects it
  task automatic card_recv(input bit nack, output bit got, output logic [10:0] bits);
    int w;
    got = 1'b0; bits = '0; w = 0;
    while (!io_pull_low && w < 800) begin @(negedge clk); w++; end
    if (!io_pull_low) return;
    got = 1'b1;
    for (int i = 0; i <= 380; i++) begin
      if (i % ETU == 16 && i / ETU <= 10) bits[i / ETU] = !io_pull_low;
      if (nack && i == 336) card_low = 1'b1;
      if (nack && i == 368) card_low = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic recv_chk(input string req, input bit nack, input logic [7:0] exp_b,
                          input bit exp_par);
    bit got;
    logic [10:0] bits;
    card_recv(nack, got, bits);
    chk({req, " frame seen"}, 8'(got), 8'h01);
    chk({req, " data"}, bits[8:1], exp_b);
    chk({req, " start/parity/guard"}, {5'd0, bits[10], bits[9], bits[0]},
        {5'd0, 1'b1, exp_par, 1'b0});
  endtask

  task automatic no_frame(input string req);
    bit got;
    logic [10:0] bits;
    card_recv(1'b0, got, bits);
    chk(req, 8'(got), 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 pull", 8'(io_pull_low), 8'h00);
    chk("R1 irq", 8'(irq), 8'h00);
    rd_chk("R1 status", AS, 8'h04);
    rd_chk("R1 ctrl", AC, 8'h17);
    rd_chk("R1 limit", AL, 8'h03);
  endtask

  task automatic t_tx_basic;
    hwr(AD, 8'hA5);
    recv_chk("R2 tx A5", 1'b0, 8'hA5, ^8'hA5);
    hwr(AD, 8'h01);
    recv_chk("R2 tx 01", 1'b0, 8'h01, 1'b1);
    wait_clk(64);
    rd_chk("R2 tx done status", AS, 8'h04);
  endtask

  task automatic t_rx_basic;
    bit s;
    card_send(8'h3C, 1'b0, s);
    chk("R3 no reject", 8'(s), 8'h00);
    rd_chk("R3 status", AS, 8'h05);
    chk("R3 irq", 8'(irq), 8'h01);
    rd_chk("R3 data", AD, 8'h3C);
    rd_chk("R3 drained", AS, 8'h04);
  endtask

  task automatic t_fifo_full;
    bit s;
    card_send(8'h11, 1'b0, s);
    card_send(8'h22, 1'b0, s);
    rd_chk("R4 rx full status", AS, 8'h07);
    card_send(8'h33, 1'b0, s);
    rd_chk("R4 rx first", AD, 8'h11);
    rd_chk("R4 rx second", AD, 8'h22);
    rd_chk("R4 third dropped", AS, 8'h04);
    hwr(AD, 8'h5E); hwr(AD, 8'h6F); hwr(AD, 8'h70);
    rd_chk("R4 tx full status", AS, 8'h08);
    recv_chk("R4 tx q0", 1'b0, 8'h5E, ^8'h5E);
    recv_chk("R4 tx q1", 1'b0, 8'h6F, ^8'h6F);
    no_frame("R4 tx overflow ignored");
  endtask

  task automatic t_parity_modes;
    bit s;
    card_send(8'h5A, 1'b1, s);
    chk("R6 reject default", 8'(s), 8'h01);
    rd_chk("R6 flag+stored", AS, 8'h15);
    chk("R6 irq", 8'(irq), 8'h01);
    rd_chk("R6 data kept", AD, 8'h5A);
    hwr(AS, 8'h10);
    rd_chk("R12 w1c parity", AS, 8'h04);
    hwr(AC, 8'h15);
    card_send(8'h24, 1'b1, s);
    chk("R6 signal only reject", 8'(s), 8'h01);
    rd_chk("R6 signal only no flag", AS, 8'h05);
    rd_chk("R6 drain1", AD, 8'h24);
    hwr(AC, 8'h13);
    card_send(8'h42, 1'b1, s);
    chk("R6 report only no reject", 8'(s), 8'h00);
    rd_chk("R6 report only flag", AS, 8'h15);
    rd_chk("R6 drain2", AD, 8'h42);
    hwr(AS, 8'h10);
    hwr(AC, 8'h16);
    card_send(8'hE7, 1'b1, s);
    chk("R5 unchecked no reject", 8'(s), 8'h00);
    rd_chk("R5 unchecked status", AS, 8'h05);
    rd_chk("R5 unchecked data", AD, 8'hE7);
    hwr(AC, 8'h37);
    card_send(8'h99, 1'b1, s);
    chk("R11 reject", 8'(s), 8'h01);
    rd_chk("R11 not stored", AS, 8'h14);
    hwr(AS, 8'h30);
    card_send(8'h0F, 1'b0, s);
    rd_chk("R11 good kept", AD, 8'h0F);
    hwr(AC, 8'h1F);
    hwr(AD, 8'hC6);
    recv_chk("R7 forced parity", 1'b0, 8'hC6, !(^8'hC6));
    hwr(AC, 8'h17);
  endtask

  task automatic t_resend;
    hwr(AL, 8'h02);
    hwr(AD, 8'h6E);
    recv_chk("R8 try0", 1'b1, 8'h6E, ^8'h6E);
    recv_chk("R8 try1", 1'b1, 8'h6E, ^8'h6E);
    recv_chk("R8 try2", 1'b1, 8'h6E, ^8'h6E);
    no_frame("R9 stop after limit");
    rd_chk("R9 exhausted flag", AS, 8'h24);
    hwr(AS, 8'h20);
    rd_chk("R12 w1c exhausted", AS, 8'h04);
    hwr(AL, 8'h00);
    hwr(AD, 8'h42);
    recv_chk("R9 limit0 try", 1'b1, 8'h42, ^8'h42);
    no_frame("R9 limit0 no resend");
    rd_chk("R9 limit0 flag", AS, 8'h24);
    hwr(AS, 8'h20);
    hwr(AL, 8'h03);
    hwr(AD, 8'h81);
    recv_chk("R8 rejected once", 1'b1, 8'h81, ^8'h81);
    recv_chk("R8 accepted resend", 1'b0, 8'h81, ^8'h81);
    no_frame("R8 done after accept");
    rd_chk("R8 no flag", AS, 8'h04);
    hwr(AC, 8'h07);
    hwr(AD, 8'h99);
    recv_chk("R10 sent", 1'b1, 8'h99, ^8'h99);
    no_frame("R10 no resend");
    rd_chk("R10 no flag", AS, 8'h04);
    hwr(AC, 8'h17);
  endtask

  task automatic t_glitch;
    @(negedge clk); card_low = 1'b1;
    wait_clk(3);
    card_low = 1'b0;
    wait_clk(500);
    rd_chk("R14 glitch ignored", AS, 8'h04);
  endtask

  task automatic t_push_pop_same_cycle;
    bit s;
    logic [7:0] v;
    for (int off = 0; off < 40; off++) begin
      card_send(8'hC3, 1'b0, s);
      fork
        card_send(8'h5D, 1'b0, s);
        begin
          wait_clk(283 + off);
          hrd(AD, v);
        end
      join
      chk("R13 popped first", v, 8'hC3);
      rd_chk("R13 second kept", AD, 8'h5D);
      rd_chk("R13 empty after", AS, 8'h04);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_tx_basic();
    t_rx_basic();
    t_fifo_full();
    t_parity_modes();
    t_resend();
    t_glitch();
    t_push_pop_same_cycle();
    summary();
    $finish;
  end
endmodule